// File: doc/BRIEF.md
# Windowed Out-of-Range Alarm Controller

This block watches a stream of monitored samples. Each sample arrives with a channel index, one per monitoring cycle for each channel. The block compares each value against a programmable lower and upper bound for that channel. When a value falls outside its window, the block records an alarm in a 16-bit status word that has one bit for each alarm source.

A global alarm flag reports whether any status bit is set. An interrupt-style alarm output is also driven. That output is gated by a per-source mask, and its polarity can be selected.

A small register port gives the host access to the bounds, the configuration, the mask and the status. Two status modes are available:
- **Latched mode:** a status bit stays set until the host reads the status register, and the read clears the word.
- **Live mode:** each bit simply follows the most recent result for its channel.

The alarm output is a plain logic-level signal.

Top module: `oor_alarm_ctrl`

## Requirements
- R1: A sample with `smp_valid` high and channel index below 12 is compared against that channel's bounds. The comparison is inclusive: a value equal to a bound is in range. The result reaches the status word at the clock edge that accepts the sample. Channel indices 12 to 15 are ignored.
- R2: The status bits are mapped as follows:
  - Channels 0..3 (current sense) set bits 0..3 when out of range on either side.
  - Channel 4 (local temperature) sets bit 4 when below its window and bit 5 when above it.
  - Channel 5 (remote sensor 1) sets bit 6 when below and bit 7 when above.
  - Channel 6 (remote sensor 2) sets bit 8 when below and bit 9 when above.
  - Channel 7 (negative supply) sets bit 10 when out of range on either side.
  - Channels 8..11 (output monitors) set bits 12..15 when out of range on either side.
  - Bit 11 always reads 0.
- R3: `global_alarm` is high exactly when some status bit is set. The same flag reads back as bit 0 of address 0x23.
- R4: Latched mode is selected when config bit 0 (latch-disable) is 0. In this mode a set status bit stays set after its channel returns in range.
- R5: In latched mode, a read of the status register (address 0x22) returns the current word and clears every bit. A channel still out of range sets its bit again on its next sample. If a detection coincides with the clearing read, the detection wins.
- R6: Live mode is selected when config bit 0 is 1. In this mode, each sample overwrites only the bits its channel owns with the new result. Reads do not clear.
- R7: A mask bit of 1 (address 0x21, same bit positions as the status word) keeps that source from driving `alarm_out`. The status bit is still recorded.
- R8: `alarm_out` is active when any unmasked status bit is set. Its polarity is set by config bit 1: 0 means active low and 1 means active high. With no active source, `alarm_out` sits at the inactive level.
- R9: After reset, the following values hold:
  - every lower bound is 0 and every upper bound is 0xFFF;
  - mask, status and configuration are all 0;
  - `alarm_out` is therefore 1.
- R10: Lower bounds are at addresses 0x00+ch and upper bounds at 0x10+ch, with the bound in data bits 11:0. A read returns data on `reg_rdata` one cycle after `reg_rd`. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Sample strobe |
| smp_chan | input | 4 | Channel index of the sample |
| smp_value | input | DW (12) | Sample code |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 6 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, registered |
| global_alarm | output | 1 | Any status bit set |
| alarm_out | output | 1 | Masked alarm output, polarity applied |

## Verification
A wrong bound or a wrong bit mapping first shows up in the status word read back after the sample. It also shows on `global_alarm` in the very next cycle.

A clear that is missing or arrives too early in latched mode shows on the second of two back-to-back status reads.

A mask or polarity fault is visible on `alarm_out` in the cycle after the status or configuration change. The bench therefore checks that pin whenever the status word is known.

// File: rtl/oor_alarm_ctrl.sv
module oor_alarm_ctrl #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_valid,
  input  logic [3:0]    smp_chan,
  input  logic [DW-1:0] smp_value,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [5:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic          global_alarm,
  output logic          alarm_out
);
  localparam int NCH = 12;
  localparam logic [5:0] A_CFG = 6'h20, A_MASK = 6'h21, A_STAT = 6'h22, A_GSTAT = 6'h23;

  logic [DW-1:0] lo_q [NCH];
  logic [DW-1:0] hi_q [NCH];
  logic          latch_dis_q, pol_q;
  logic [15:0]   mask_q, stat_q, stat_d;
  logic          below, above;
  logic [15:0]   own, evt;
  logic [15:0]   rd_mux;

  wire rd_stat = reg_rd && (reg_addr == A_STAT);

  always_comb begin
    below = 1'b0;
    above = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (smp_chan == 4'(i)) begin
        below = smp_value < lo_q[i];
        above = smp_value > hi_q[i];
      end
  end

  always_comb begin
    own = '0;
    evt = '0;
    if (smp_valid) begin
      case (smp_chan)
        4'd0, 4'd1, 4'd2, 4'd3: begin
          own[smp_chan[1:0]] = 1'b1;
          evt[smp_chan[1:0]] = below | above;
        end
        4'd4: begin own[5:4] = 2'b11; evt[5:4] = {above, below}; end
        4'd5: begin own[7:6] = 2'b11; evt[7:6] = {above, below}; end
        4'd6: begin own[9:8] = 2'b11; evt[9:8] = {above, below}; end
        4'd7: begin own[10]  = 1'b1;  evt[10]  = below | above; end
        4'd8, 4'd9, 4'd10, 4'd11: begin
          own[12 + smp_chan[1:0]] = 1'b1;
          evt[12 + smp_chan[1:0]] = below | above;
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    if (latch_dis_q) stat_d = (stat_q & ~own) | evt;
    else             stat_d = (rd_stat ? 16'h0 : stat_q) | evt;
    stat_d[11] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        lo_q[i] <= '0;
        hi_q[i] <= '1;
      end
      latch_dis_q <= 1'b0;
      pol_q       <= 1'b0;
      mask_q      <= '0;
      stat_q      <= '0;
    end else begin
      stat_q <= stat_d;
      if (reg_wr) begin
        for (int i = 0; i < NCH; i++) begin
          if (reg_addr == 6'(i))        lo_q[i] <= reg_wdata[DW-1:0];
          if (reg_addr == 6'(16 + i))   hi_q[i] <= reg_wdata[DW-1:0];
        end
        if (reg_addr == A_CFG) begin
          latch_dis_q <= reg_wdata[0];
          pol_q       <= reg_wdata[1];
        end
        if (reg_addr == A_MASK) mask_q <= reg_wdata;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (reg_addr == 6'(i))      rd_mux = 16'(lo_q[i]);
      if (reg_addr == 6'(16 + i)) rd_mux = 16'(hi_q[i]);
    end
    case (reg_addr)
      A_CFG:   rd_mux = {14'h0, pol_q, latch_dis_q};
      A_MASK:  rd_mux = mask_q;
      A_STAT:  rd_mux = stat_q;
      A_GSTAT: rd_mux = {15'h0, global_alarm};
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      reg_rdata <= '0;
    else if (reg_rd) reg_rdata <= rd_mux;
  end

  assign global_alarm = |stat_q;
  assign alarm_out    = pol_q ? |(stat_q & ~mask_q) : ~|(stat_q & ~mask_q);
endmodule

// File: rtl/oor_alarm_chk.sv
module oor_alarm_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        smp_valid,
  input logic        reg_rd,
  input logic [5:0]  reg_addr,
  input logic [15:0] reg_rdata,
  input logic        global_alarm,
  input logic        alarm_out,
  input logic        latch_dis,
  input logic        pol
);
  wire rd_stat = reg_rd && (reg_addr == 6'h22);

  p_rsv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stat |=> reg_rdata[11] == 1'b0);

  p_gstat_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 6'h23) |=> reg_rdata[0] == $past(global_alarm));

  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (global_alarm && !latch_dis && !rd_stat) |=> global_alarm);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !latch_dis && !smp_valid) |=> !global_alarm);

  p_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_valid && !rd_stat) |=> $stable(global_alarm));

  p_idle_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !global_alarm |-> (alarm_out == !pol));
endmodule

bind oor_alarm_ctrl oor_alarm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_rdata(reg_rdata), .global_alarm(global_alarm),
  .alarm_out(alarm_out), .latch_dis(latch_dis_q), .pol(pol_q)
);

// File: tb/oor_alarm_ctrl_tb.sv
`timescale 1ns/1ps
module oor_alarm_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_valid = 1'b0;
  logic [3:0] smp_chan = '0;
  logic [11:0] smp_value = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic global_alarm, alarm_out;

  int n_chk = 0, n_bad = 0;
  logic [15:0] rv;

  always #2 clk = ~clk;

  oor_alarm_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_chan(smp_chan),
    .smp_value(smp_value), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .global_alarm(global_alarm),
    .alarm_out(alarm_out)
  );

  // {chan[3:0], value[11:0], expected status[15:0]}, live mode, all windows 100..200
  localparam logic [31:0] VEC [16] = '{
    32'h0_032_0001, 32'h0_096_0000, 32'h4_063_0010, 32'h4_0C9_0020,
    32'h5_064_0020, 32'h5_0C8_0020, 32'h6_0C9_0220, 32'h6_000_0120,
    32'h7_12C_0520, 32'h8_FFF_1520, 32'hB_00A_9520, 32'h4_096_9500,
    32'hC_FFF_9500, 32'h3_0C9_9508, 32'h7_096_9108, 32'h5_063_9148
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [15:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic smp(input logic [3:0] c, input logic [11:0] v);
    @(negedge clk); smp_valid = 1'b1; smp_chan = c; smp_value = v;
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic smp_rd(input logic [3:0] c, input logic [11:0] v, output logic [15:0] d);
    @(negedge clk); smp_valid = 1'b1; smp_chan = c; smp_value = v;
    reg_rd = 1'b1; reg_addr = 6'h22;
    @(negedge clk); smp_valid = 1'b0; reg_rd = 1'b0; d = reg_rdata;
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset state
    chk("R9 alarm_out", {15'h0, alarm_out}, 16'h1);
    chk("R9 global", {15'h0, global_alarm}, 16'h0);
    rd(6'h00, rv); chk("R9 lo0", rv, 16'h000);
    rd(6'h1B, rv); chk("R9 hi11", rv, 16'hFFF);
    rd(6'h21, rv); chk("R9 mask", rv, 16'h0);
    rd(6'h20, rv); chk("R9 cfg", rv, 16'h0);
    rd(6'h22, rv); chk("R9 stat", rv, 16'h0);
    rd(6'h3F, rv); chk("R10 unmapped", rv, 16'h0);

    for (int i = 0; i < 12; i++) begin
      wr(6'(i), 16'd100);
      wr(6'(16 + i), 16'd200);
    end
    rd(6'h15, rv); chk("R10 hi5 readback", rv, 16'd200);
    wr(6'h20, 16'h0001);

    // Vector table: R1 R2 R6
    foreach (VEC[k]) begin
      smp(VEC[k][31:28], VEC[k][27:16]);
      chk("R1/R2 global", {15'h0, global_alarm}, {15'h0, VEC[k][15:0] != 16'h0});
      rd(6'h22, rv); chk("R1/R2/R6 status", rv, VEC[k][15:0]);
    end
    rd(6'h22, rv); chk("R6 read does not clear", rv, 16'h9148);
    rd(6'h23, rv); chk("R3 gstat", rv, 16'h1);

    // R8 polarity, R7 mask
    chk("R8 active low", {15'h0, alarm_out}, 16'h0);
    wr(6'h21, 16'hFFFF);
    chk("R7 all masked", {15'h0, alarm_out}, 16'h1);
    rd(6'h22, rv); chk("R7 status kept", rv, 16'h9148);
    wr(6'h20, 16'h0003);
    chk("R7 masked high pol", {15'h0, alarm_out}, 16'h0);
    wr(6'h21, 16'hFFFE);
    smp(4'd0, 12'd201);
    chk("R8 active high", {15'h0, alarm_out}, 16'h1);

    // latched mode, polarity high
    wr(6'h21, 16'h0000);
    wr(6'h20, 16'h0002);
    rd(6'h22, rv); chk("R5 read returns word", rv, 16'h9149);
    rd(6'h22, rv); chk("R5 cleared", rv, 16'h0);
    chk("R3 global after clear", {15'h0, global_alarm}, 16'h0);
    chk("R8 idle high pol", {15'h0, alarm_out}, 16'h0);
    smp(4'd2, 12'd50);
    smp(4'd2, 12'd150);
    chk("R4 sticky global", {15'h0, global_alarm}, 16'h1);
    rd(6'h22, rv); chk("R4 sticky", rv, 16'h0004);
    rd(6'h22, rv); chk("R5 clear", rv, 16'h0);
    smp(4'd2, 12'd50);
    rd(6'h22, rv);
    smp(4'd2, 12'd50);
    rd(6'h22, rv); chk("R5 reassert", rv, 16'h0004);
    smp_rd(4'd9, 12'd300, rv); chk("R5 coincident read old", rv, 16'h0);
    rd(6'h22, rv); chk("R5 detection wins", rv, 16'h2000);
    smp(4'd4, 12'd100);
    smp(4'd4, 12'd200);
    rd(6'h22, rv); chk("R1 inclusive bounds", rv, 16'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule